// File: doc/BRIEF.md
# Serial Byte Transceiver with Four-Phase Handshake

This block joins an asynchronous serial line to a byte-oriented command processor that runs on the same clock. The receive half deserializes incoming frames and checks their parity. It hands each good byte to the processor through a strobe/acknowledge exchange that runs through all four phases. The transmit half accepts bytes from the processor over a matching exchange. It acknowledges each byte once it has latched it and shifts the byte out on the line.

A frame is one start bit (low), eight data bits sent least significant bit first, one even parity bit and two stop bits (high). The number of clock cycles per bit is the parameter `CLKS_PER_BIT`. For 1200 baud it is set to the clock frequency divided by 1200. The block does not interpret the bytes. Framing bytes that mark the start and end of a message pass through like any other data. The format is fixed, and there are no flow-control pins.

The receiver passes the line through two flip-flops. It confirms a start bit at half a bit time and then samples every later bit at its middle. A frame with a bad parity bit or a low stop bit is discarded and raises a sticky frame-error output. A byte that completes while the previous byte is still in its handshake is discarded and raises a sticky overrun output.

Top module: `serial_byte_link`

## Requirements
- R1: After reset, `ser_out` is high, `rx_stb` and `tx_ack` are low, and `frame_err` and `overrun` are low.
- R2: The transmitted frame has these bits in order: a low start bit, eight data bits least significant first, a parity bit equal to the XOR of the eight data bits (even parity), and two high stop bits. Each bit lasts `CLKS_PER_BIT` cycles.
- R3: When `tx_stb` is high and the transmitter is idle, `tx_ack` goes high on the next clock edge and the byte is latched. A later change of `tx_data` does not alter the byte sent. `tx_ack` stays high while `tx_stb` stays high and goes low on the first edge that sees `tx_stb` low.
- R4: While a frame is still being shifted out, a new `tx_stb` is not acknowledged. `tx_ack` rises only once the line is idle, in the same cycle the next start bit begins.
- R5: A correctly framed byte appears on `rx_data` with `rx_stb` high. Both hold steady until `rx_ack` is seen high.
- R6: `rx_stb` falls on the edge after `rx_ack` is seen high. No new byte is offered while `rx_ack` is still high.
- R7: A low pulse on `ser_in` shorter than half a bit time is ignored. It produces no byte and no error.
- R8: A frame whose parity bit does not make the count of ones in data plus parity even is discarded and sets `frame_err`.
- R9: A frame with a low first or second stop bit is discarded and sets `frame_err`.
- R10: A byte that completes while the previous byte has not finished its handshake is discarded. The pending byte is unchanged, and `overrun` is set.
- R11: `frame_err` and `overrun` stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial line in, idle high |
| ser_out | output | 1 | Serial line out, idle high |
| rx_stb | output | 1 | Received byte offered |
| rx_data | output | 8 | Received byte |
| rx_ack | input | 1 | Consumer acknowledge for the received byte |
| tx_stb | input | 1 | Producer offers a byte to send |
| tx_data | input | 8 | Byte to send |
| tx_ack | output | 1 | Byte to send has been latched |
| frame_err | output | 1 | Sticky: a parity or stop-bit fault was seen |
| overrun | output | 1 | Sticky: a received byte was lost |

## Verification
The receiver gets several good bytes, which are compared through a queue with what the consumer takes. It then gets a sub-half-bit glitch, a frame with flipped parity, and frames with the first or the second stop bit low. These separate the glitch filter from the parity check and from the two stop-bit checks, with a reset between cases so that each sticky flag is credited to a single cause. A stalled consumer exposes overrun and shows that the pending byte is held. Transmit bytes are offered both to an idle transmitter and back to back, which separates the immediate acknowledge from the acknowledge that waits for the line. The data lines are changed after the acknowledge to show that the byte was latched.

// File: rtl/serial_byte_link.sv
module serial_byte_link #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_in,
  output logic       ser_out,
  output logic       rx_stb,
  output logic [7:0] rx_data,
  input  logic       rx_ack,
  input  logic       tx_stb,
  input  logic [7:0] tx_data,
  output logic       tx_ack,
  output logic       frame_err,
  output logic       overrun
);
  localparam int CW = $clog2(CLKS_PER_BIT + 1);
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] MID  = CW'(CLKS_PER_BIT / 2 - 1);
  localparam int FRAME_BITS = 12;
  localparam logic [3:0] FRAME_LEN = 4'(FRAME_BITS);

  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP1, R_STOP2} rx_state_t;
  typedef enum logic [1:0] {H_FREE, H_OFFER, H_DRAIN} hs_state_t;

  logic            sync1, sync2;
  rx_state_t       rstate;
  logic [CW-1:0]   rcnt;
  logic [2:0]      ridx;
  logic [7:0]      rshift;
  logic            rbad;
  hs_state_t       hs;
  logic            rtick, deliver, finish;

  assign rtick   = (rcnt == LAST);
  assign finish  = (rstate == R_STOP2) && rtick;
  assign deliver = finish && !rbad && sync2 && (hs == H_FREE);
  assign rx_stb  = (hs == H_OFFER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1     <= 1'b1;
      sync2     <= 1'b1;
      rstate    <= R_IDLE;
      rcnt      <= '0;
      ridx      <= '0;
      rshift    <= '0;
      rbad      <= 1'b0;
      frame_err <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      sync1 <= ser_in;
      sync2 <= sync1;
      case (rstate)
        R_IDLE: if (!sync2) begin
          rstate <= R_START;
          rcnt   <= '0;
        end
        R_START: begin
          if (sync2) rstate <= R_IDLE;
          else if (rcnt == MID) begin
            rstate <= R_DATA;
            rcnt   <= '0;
            ridx   <= '0;
            rbad   <= 1'b0;
          end else rcnt <= rcnt + 1'b1;
        end
        default: begin
          if (!rtick) rcnt <= rcnt + 1'b1;
          else begin
            rcnt <= '0;
            case (rstate)
              R_DATA: begin
                rshift <= {sync2, rshift[7:1]};
                if (ridx == 3'd7) rstate <= R_PAR;
                ridx <= ridx + 1'b1;
              end
              R_PAR: begin
                rbad   <= ((^rshift) != sync2);
                rstate <= R_STOP1;
              end
              R_STOP1: begin
                if (!sync2) rbad <= 1'b1;
                rstate <= R_STOP2;
              end
              default: begin
                rstate <= R_IDLE;
                if (rbad || !sync2) frame_err <= 1'b1;
                else if (hs != H_FREE) overrun <= 1'b1;
              end
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs      <= H_FREE;
      rx_data <= '0;
    end else begin
      case (hs)
        H_FREE:  if (deliver) begin
          hs      <= H_OFFER;
          rx_data <= rshift;
        end
        H_OFFER: if (rx_ack) hs <= H_DRAIN;
        default: if (!rx_ack) hs <= H_FREE;
      endcase
    end
  end

  logic [FRAME_BITS-1:0] tshift;
  logic [3:0]            tleft;
  logic [CW-1:0]         tcnt;

  assign ser_out = (tleft != 4'd0) ? tshift[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tshift <= '1;
      tleft  <= '0;
      tcnt   <= '0;
      tx_ack <= 1'b0;
    end else begin
      if (!tx_ack && tx_stb && tleft == 4'd0) begin
        tx_ack <= 1'b1;
        tshift <= {2'b11, ^tx_data, tx_data, 1'b0};
        tleft  <= FRAME_LEN;
        tcnt   <= '0;
      end else begin
        if (tx_ack && !tx_stb) tx_ack <= 1'b0;
        if (tleft != 4'd0) begin
          if (tcnt == LAST) begin
            tcnt   <= '0;
            tshift <= {1'b1, tshift[FRAME_BITS-1:1]};
            tleft  <= tleft - 1'b1;
          end else tcnt <= tcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/serial_byte_link_chk.sv
module serial_byte_link_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ser_in,
  input logic       ser_out,
  input logic       rx_stb,
  input logic [7:0] rx_data,
  input logic       rx_ack,
  input logic       tx_stb,
  input logic [7:0] tx_data,
  input logic       tx_ack,
  input logic       frame_err,
  input logic       overrun
);
  a_r5_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb && !rx_ack |=> rx_stb && $stable(rx_data));

  a_r6_stb_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb && rx_ack |=> !rx_stb);

  a_r6_no_reoffer: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_stb && rx_ack |=> !rx_stb);

  a_r3_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack && tx_stb |=> tx_ack);

  a_r3_ack_fall: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack && !tx_stb |=> !tx_ack);

  a_r4_ack_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ack) |-> !ser_out);

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);

  a_r11_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind serial_byte_link serial_byte_link_chk u_chk (.*);

// File: tb/tb_serial_byte_link.sv
module tb_serial_byte_link;
  localparam int CLK_PERIOD = 10;
  localparam int CPB = 16;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b1;
  logic ser_out, rx_stb, rx_ack = 1'b0, tx_stb = 1'b0, tx_ack;
  logic [7:0] rx_data, tx_data = 8'h00;
  logic frame_err, overrun;

  int compared = 0, mismatched = 0, cycles = 0;
  logic stall = 1'b0;
  logic [7:0] rx_q[$];
  logic [7:0] tx_q[$];

  serial_byte_link #(.CLKS_PER_BIT(CPB)) dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_out(ser_out),
    .rx_stb(rx_stb), .rx_data(rx_data), .rx_ack(rx_ack),
    .tx_stb(tx_stb), .tx_data(tx_data), .tx_ack(tx_ack),
    .frame_err(frame_err), .overrun(overrun));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      summary();
    end
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit flip_par,
                            input bit stop1, input bit stop2);
    logic [11:0] bits;
    bits = {stop2, stop1, (^d) ^ flip_par, d, 1'b0};
    for (int b = 0; b < 12; b++) begin
      ser_in = bits[b];
      wait_cycles(CPB);
    end
    ser_in = 1'b1;
  endtask

  task automatic rx_good(input logic [7:0] d);
    rx_q.push_back(d);
    send_frame(d, 1'b0, 1'b1, 1'b1);
    wait_cycles(CPB);
  endtask

  task automatic do_reset();
    wait (rx_q.size() == 0 && tx_q.size() == 0);
    wait_cycles(2 * CPB);
    rst_n = 1'b0;
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(2);
  endtask

  task automatic tx_send(input logic [7:0] d, output int waited);
    tx_data = d;
    tx_stb  = 1'b1;
    waited  = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!tx_ack);
    tx_q.push_back(d);
    tx_data = ~d;
    tx_stb  = 1'b0;
    @(negedge clk);
    check(tx_ack == 1'b0, "R3 ack falls after strobe drops", tx_ack, 0);
  endtask

  // receive consumer and scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rx_stb) begin
        while (stall) @(negedge clk);
        if (rx_q.size() == 0)
          check(1'b0, "R5 unexpected received byte", rx_data, 0);
        else begin
          logic [7:0] e;
          e = rx_q.pop_front();
          check(rx_data == e, "R5 received byte", rx_data, e);
        end
        rx_ack = 1'b1;
        @(negedge clk);
        check(rx_stb == 1'b0, "R6 strobe falls after ack", rx_stb, 0);
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          check(rx_stb == 1'b0, "R6 no offer while ack high", rx_stb, 0);
        end
        rx_ack = 1'b0;
      end
    end
  end

  // transmit line monitor and scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && ser_out == 1'b0) begin
        logic [11:0] got;
        logic [7:0] e;
        wait_cycles(CPB/2);
        got[0] = ser_out;
        for (int b = 1; b < 12; b++) begin
          wait_cycles(CPB);
          got[b] = ser_out;
        end
        if (tx_q.size() == 0) check(1'b0, "R2 unexpected frame", got, 0);
        else begin
          e = tx_q.pop_front();
          check(got == {2'b11, ^e, e, 1'b0}, "R2 R3 transmitted frame", got, {2'b11, ^e, e, 1'b0});
        end
        wait_cycles(CPB/2 - 1);
      end
    end
  end

  initial begin
    int w;
    wait_cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    check(ser_out == 1'b1, "R1 ser_out idle", ser_out, 1);
    check(rx_stb == 1'b0 && tx_ack == 1'b0, "R1 strobes low", {rx_stb, tx_ack}, 0);
    check(frame_err == 1'b0 && overrun == 1'b0, "R1 flags low", {frame_err, overrun}, 0);

    rx_good(8'h55);
    rx_good(8'hA5);
    rx_good(8'h00);
    rx_good(8'hFF);
    rx_good(8'h01);
    rx_good(8'h80);

    // R7 glitch shorter than half a bit
    ser_in = 1'b0;
    wait_cycles(CPB/2 - 1);
    ser_in = 1'b1;
    wait_cycles(16 * CPB);
    check(frame_err == 1'b0, "R7 glitch gives no error", frame_err, 0);
    rx_good(8'h3C);

    // R8 parity fault
    do_reset();
    send_frame(8'h96, 1'b1, 1'b1, 1'b1);
    wait_cycles(2 * CPB);
    check(frame_err == 1'b1, "R8 parity fault flagged", frame_err, 1);
    rx_good(8'h69);
    check(frame_err == 1'b1, "R11 frame_err sticky", frame_err, 1);

    // R9 first stop bit low
    do_reset();
    check(frame_err == 1'b0, "R1 flag cleared by reset", frame_err, 0);
    send_frame(8'h12, 1'b0, 1'b0, 1'b1);
    wait_cycles(2 * CPB);
    check(frame_err == 1'b1, "R9 first stop low flagged", frame_err, 1);

    // R9 second stop bit low
    do_reset();
    send_frame(8'h34, 1'b0, 1'b1, 1'b0);
    wait_cycles(30 * CPB);
    check(frame_err == 1'b1, "R9 second stop low flagged", frame_err, 1);

    // R10 overrun while consumer stalls
    do_reset();
    stall = 1'b1;
    rx_q.push_back(8'hC3);
    send_frame(8'hC3, 1'b0, 1'b1, 1'b1);
    wait_cycles(CPB);
    send_frame(8'h7E, 1'b0, 1'b1, 1'b1);
    wait_cycles(CPB);
    check(overrun == 1'b1, "R10 overrun flagged", overrun, 1);
    check(rx_stb == 1'b1 && rx_data == 8'hC3, "R10 pending byte kept", rx_data, 8'hC3);
    check(frame_err == 1'b0, "R10 no frame error", frame_err, 0);
    stall = 1'b0;
    wait (rx_q.size() == 0);
    wait_cycles(10);
    check(overrun == 1'b1, "R11 overrun sticky", overrun, 1);

    // transmit side
    do_reset();
    tx_send(8'hB4, w);
    check(w == 1, "R3 idle ack latency", w, 1);
    tx_send(8'h0F, w);
    check(w > 11 * CPB, "R4 ack waits for idle line", w, 12 * CPB);
    tx_send(8'hE7, w);
    check(w > 11 * CPB, "R4 ack waits for idle line", w, 12 * CPB);
    wait (tx_q.size() == 0);
    wait_cycles(2 * CPB);
    check(ser_out == 1'b1, "R2 line idle after frames", ser_out, 1);
    check(rx_q.size() == 0 && tx_q.size() == 0, "R5 scoreboard drained",
          rx_q.size() + tx_q.size(), 0);
    summary();
  end
endmodule